// File: doc/BRIEF.md
# Single-Precision Compare Unit with Sticky Status Flags

This block compares two IEEE-754 single-precision operands and returns a one-bit answer, one cycle after the request. It can perform seven predicates: unordered, less-than, equal, less-or-equal, greater-than, not-equal and greater-or-equal. The predicates do not all use the same operand order. Some are quiet and some are signalling. Greater-or-equal and not-equal are formed as complements, so both answer 1 when an operand is NaN.

The unit also holds a small floating-point status register with four sticky flags: invalid-operation, divide-by-zero, overflow and underflow. Each compare can raise the invalid flag. A neighbouring arithmetic unit raises any of the four flags through a flag input. Software reloads the register with a write strobe. When a flag is raised and both exception enables are set, the block requests an FPU exception for one cycle.

Opcode encoding on `op_sel`:
- 0 unordered
- 1 less-than
- 2 equal
- 3 less-or-equal
- 4 greater-than
- 5 not-equal
- 6 greater-or-equal
- 7 reserved

Top module: `fp_cmp_flags`

## Requirements
- R1: Unordered (op 0) answers 1 when either operand is a NaN (exponent all ones, mantissa non-zero). It raises invalid only when an operand is a signalling NaN (mantissa bit 22 clear); a quiet NaN has bit 22 set.
- R2: Less-than (op 1) answers 1 when b < a. Greater-than (op 4) answers 1 when a < b. Both answer 0 for NaN operands.
- R3: Less-or-equal (op 3) answers 1 when a <= b, and 0 for NaN operands.
- R4: Greater-or-equal (op 6) answers the complement of (a < b), so it answers 1 whenever an operand is a NaN.
- R5: Equal (op 2) is quiet: it answers 0 for any NaN and raises invalid only for a signalling NaN. Not-equal (op 5) is its complement. +0 and -0 compare equal. Non-NaN values otherwise order by sign and magnitude, infinities included.
- R6: Ops 1, 3, 4 and 6 raise invalid for any NaN operand, quiet or signalling.
- R7: `status` bit 4 is invalid, bit 3 divide-by-zero, bit 2 overflow, bit 1 underflow, and bit 0 always reads 0. `ext_flags[3:0]` raises the same four flags in the order {invalid, divide-by-zero, overflow, underflow}. Every flag is a sticky OR and changes on the clock edge that samples the request.
- R8: `exc_req` pulses in the cycle after a flag is raised, but only when `fpu_exc_en` and `exc_glb_en` are both 1 in the raising cycle. The pulse occurs even if that flag was already set.
- R9: `stat_wr` loads `stat_wdata[4:1]` into the flags. A flag raised in the same cycle as the write is set regardless of the written value.
- R10: Reset clears every output. `res_vld` follows `op_valid` one cycle later. `res` is 0 in cycles without a request. Op 7 answers 0 and raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Compare request |
| op_sel | input | 3 | Predicate select |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| ext_flags | input | 4 | Flags raised by an arithmetic unit {inv, dz, of, uf} |
| stat_wr | input | 1 | Software write strobe for the status flags |
| stat_wdata | input | 5 | Write data, bits 4:1 used |
| fpu_exc_en | input | 1 | FPU exception enabled in configuration |
| exc_glb_en | input | 1 | Exceptions globally enabled |
| res | output | 1 | Compare answer |
| res_vld | output | 1 | Answer valid |
| status | output | 5 | Sticky status flags |
| exc_req | output | 1 | One-cycle FPU exception request |

## Verification
Three things can occur in the same cycle:
- a compare that raises invalid,
- an arithmetic flag on `ext_flags`,
- a software write that clears or sets the flags.

When they coincide, the raise must survive the write. The bench drives random mixes of NaN-heavy operands, external flags and write strobes, so these collisions happen often. A behavioural model built on signed integer keys predicts the status, result and exception request every cycle. This lets the bench judge whether a written 0 was correctly overridden by a same-cycle raise, and whether an exception pulse was correctly gated by the enables.

// File: rtl/fp_cmp_flags.sv
module fp_cmp_flags #(
  parameter int W     = 32,
  parameter int EXP_W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [2:0]   op_sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   ext_flags,
  input  logic         stat_wr,
  input  logic [4:0]   stat_wdata,
  input  logic         fpu_exc_en,
  input  logic         exc_glb_en,
  output logic         res,
  output logic         res_vld,
  output logic [4:0]   status,
  output logic         exc_req
);
  localparam int MW = W - EXP_W - 1;

  logic a_nan, b_nan, a_snan, b_snan, any_nan, any_snan, both_zero;
  logic [W-2:0] mag_a, mag_b;

  assign mag_a    = a[W-2:0];
  assign mag_b    = b[W-2:0];
  assign a_nan    = (&a[W-2:MW]) && (|a[MW-1:0]);
  assign b_nan    = (&b[W-2:MW]) && (|b[MW-1:0]);
  assign a_snan   = a_nan && !a[MW-1];
  assign b_snan   = b_nan && !b[MW-1];
  assign any_nan  = a_nan || b_nan;
  assign any_snan = a_snan || b_snan;
  assign both_zero = (mag_a == '0) && (mag_b == '0);

  logic a_lt_b, b_lt_a, a_eq_b;
  always_comb begin
    if (both_zero) begin
      a_lt_b = 1'b0; b_lt_a = 1'b0; a_eq_b = 1'b1;
    end else if (a[W-1] != b[W-1]) begin
      a_lt_b = a[W-1]; b_lt_a = b[W-1]; a_eq_b = 1'b0;
    end else if (!a[W-1]) begin
      a_lt_b = mag_a < mag_b; b_lt_a = mag_b < mag_a; a_eq_b = mag_a == mag_b;
    end else begin
      a_lt_b = mag_a > mag_b; b_lt_a = mag_b > mag_a; a_eq_b = mag_a == mag_b;
    end
  end

  logic ord_ab, ord_ba, ord_eq;
  assign ord_ab = !any_nan && a_lt_b;
  assign ord_ba = !any_nan && b_lt_a;
  assign ord_eq = !any_nan && a_eq_b;

  logic cmp_r, cmp_inv;
  always_comb begin
    unique case (op_sel)
      3'd0:    begin cmp_r = any_nan;          cmp_inv = any_snan; end
      3'd1:    begin cmp_r = ord_ba;           cmp_inv = any_nan;  end
      3'd2:    begin cmp_r = ord_eq;           cmp_inv = any_snan; end
      3'd3:    begin cmp_r = ord_ab || ord_eq; cmp_inv = any_nan;  end
      3'd4:    begin cmp_r = ord_ab;           cmp_inv = any_nan;  end
      3'd5:    begin cmp_r = !ord_eq;          cmp_inv = any_snan; end
      3'd6:    begin cmp_r = !ord_ab;          cmp_inv = any_nan;  end
      default: begin cmp_r = 1'b0;             cmp_inv = 1'b0;     end
    endcase
  end

  logic [3:0] flags_q, raise, flags_base;
  assign raise      = ext_flags | {op_valid && cmp_inv, 3'b000};
  assign flags_base = stat_wr ? stat_wdata[4:1] : flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      res     <= 1'b0;
      res_vld <= 1'b0;
      exc_req <= 1'b0;
    end else begin
      flags_q <= flags_base | raise;
      res     <= op_valid && cmp_r;
      res_vld <= op_valid;
      exc_req <= (|raise) && fpu_exc_en && exc_glb_en;
    end
  end

  assign status = {flags_q, 1'b0};
endmodule

module fp_cmp_flags_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [2:0]  op_sel,
  input logic [31:0] a,
  input logic [31:0] b,
  input logic [3:0]  ext_flags,
  input logic        stat_wr,
  input logic        fpu_exc_en,
  input logic        exc_glb_en,
  input logic        res,
  input logic        res_vld,
  input logic [4:0]  status,
  input logic        exc_req
);
  logic chk_a_nan, chk_b_nan;
  assign chk_a_nan = (a[30:23] == 8'hFF) && (a[22:0] != 0);
  assign chk_b_nan = (b[30:23] == 8'hFF) && (b[22:0] != 0);

  assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_vld);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!res_vld && !res));
  assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((status & $past(status)) == $past(status)));
  assert_ext_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_flags != 0) |=> ((status[4:1] & $past(ext_flags)) == $past(ext_flags)));
  assert_exc_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> $past(fpu_exc_en && exc_glb_en));
  assert_unord_nan_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 3'd0 && (chk_a_nan || chk_b_nan)) |=> res);
  assert_ge_nan_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == 3'd6 && (chk_a_nan || chk_b_nan)) |=> (res && status[4]));
endmodule

bind fp_cmp_flags fp_cmp_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel), .a(a), .b(b),
  .ext_flags(ext_flags), .stat_wr(stat_wr), .fpu_exc_en(fpu_exc_en),
  .exc_glb_en(exc_glb_en), .res(res), .res_vld(res_vld), .status(status),
  .exc_req(exc_req)
);

// File: tb/fp_cmp_flags_test.sv
module fp_cmp_flags_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [2:0] op_sel = '0;
  logic [31:0] a = '0, b = '0;
  logic [3:0] ext_flags = '0;
  logic stat_wr = 1'b0;
  logic [4:0] stat_wdata = '0;
  logic fpu_exc_en = 1'b0, exc_glb_en = 1'b0;
  logic res, res_vld, exc_req;
  logic [4:0] status;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [3:0] m_flags = '0;

  always #5 clk = ~clk;

  fp_cmp_flags uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel), .a(a), .b(b),
    .ext_flags(ext_flags), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .fpu_exc_en(fpu_exc_en), .exc_glb_en(exc_glb_en), .res(res),
    .res_vld(res_vld), .status(status), .exc_req(exc_req)
  );

  logic [31:0] pool [10] = '{32'h3F800000, 32'h40000000, 32'hBF800000, 32'hC0000000,
                             32'h00000000, 32'h80000000, 32'h7FC00000, 32'h7F800001,
                             32'h7F800000, 32'hFF800000};

  function automatic bit is_nan(logic [31:0] x);
    return x[30:23] == 8'hFF && x[22:0] != 0;
  endfunction
  function automatic bit is_snan(logic [31:0] x);
    return is_nan(x) && x[22] == 1'b0;
  endfunction
  function automatic longint key(logic [31:0] x);
    longint m = longint'(x[30:0]);
    return x[31] ? -m : m;
  endfunction

  function automatic string tag_of(logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1, 3'd4: return "R2";
      3'd3: return "R3";
      3'd6: return "R4";
      3'd2, 3'd5: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(bit v, logic [2:0] op, logic [31:0] x, logic [31:0] y,
                      logic [3:0] ef, bit wr, logic [4:0] wd, bit en1, bit en2);
    bit nan, snan, r, inv;
    logic [3:0] raise;
    bit exp_exc;
    op_valid = v; op_sel = op; a = x; b = y; ext_flags = ef;
    stat_wr = wr; stat_wdata = wd; fpu_exc_en = en1; exc_glb_en = en2;
    nan  = is_nan(x) || is_nan(y);
    snan = is_snan(x) || is_snan(y);
    case (op)
      3'd0: begin r = nan; inv = snan; end
      3'd1: begin r = !nan && key(y) < key(x); inv = nan; end
      3'd2: begin r = !nan && key(x) == key(y); inv = snan; end
      3'd3: begin r = !nan && key(x) <= key(y); inv = nan; end
      3'd4: begin r = !nan && key(x) < key(y); inv = nan; end
      3'd5: begin r = !(!nan && key(x) == key(y)); inv = snan; end
      3'd6: begin r = !(!nan && key(x) < key(y)); inv = nan; end
      default: begin r = 0; inv = 0; end
    endcase
    if (!v) begin r = 0; inv = 0; end
    raise = ef | {inv, 3'b000};
    m_flags = (wr ? wd[4:1] : m_flags) | raise;
    exp_exc = (raise != 0) && en1 && en2;
    @(posedge clk);
    @(negedge clk);
    check(tag_of(op), "res", res, r);
    check("R10", "res_vld", res_vld, v);
    check((inv ? "R6" : (wr ? "R9" : "R7")), "status", status, {m_flags, 1'b0});
    check("R8", "exc_req", exc_req, exp_exc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "reset res", res, 0);
    check("R10", "reset res_vld", res_vld, 0);
    check("R10", "reset status", status, 0);
    check("R10", "reset exc_req", exc_req, 0);
    rst_n = 1'b1;
    // exhaustive op x operand sweep with enables on
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          step(1, op[2:0], pool[i], pool[j], 4'h0, (i == 0 && j == 0), 5'h00, 1, 1);
    // R9: clear collides with a signalling-NaN raise
    step(1, 3'd0, 32'h7F800001, 32'h3F800000, 4'h0, 1, 5'h00, 1, 1);
    step(0, 3'd0, 0, 0, 4'h0, 1, 5'h00, 1, 1);
    // R8: raise with one enable off gives no request
    step(0, 3'd0, 0, 0, 4'h2, 0, 5'h00, 1, 0);
    step(0, 3'd0, 0, 0, 4'h4, 0, 5'h00, 0, 1);
    step(0, 3'd0, 0, 0, 4'h1, 0, 5'h00, 1, 1);
    // R10: reserved op raises nothing
    step(1, 3'd7, 32'h7F800001, 32'h7F800001, 4'h0, 1, 5'h00, 1, 1);
    step(1, 3'd7, 32'h7F800001, 32'h7F800001, 4'h0, 0, 5'h00, 1, 1);
    // random collisions
    for (int k = 0; k < 1500; k++) begin
      logic [3:0] ef;
      ef = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
      step($urandom_range(0, 3) != 0, 3'($urandom), pool[$urandom_range(0, 9)],
           pool[$urandom_range(0, 9)], ef, $urandom_range(0, 5) == 0,
           5'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule